// File: doc/BRIEF.md
# Completion event interrupt generator

This block turns the completion of a flagged invalidation wait into one message-signalled interrupt. A completion pulse that carries an interrupt-request flag sets a wait-complete status bit. If that bit was clear beforehand, the event also raises a pending flag. The block then offers a message on a valid/ready output. The message carries the programmed data word. A mask bit holds the message back, and so does a sink that is not ready. The pending flag clears when the handshake completes. It also clears, with no message sent, when software clears the status bit.

Software sees three 32-bit registers through a simple port. Writes are single-cycle and reads are combinational:
- Status at 0x9C: bit 0 is the wait-complete bit, cleared by writing 1.
- Control at 0xA0: bit 31 is the mask, bit 30 is the read-only pending flag, and bits 29:0 are reserved.
- Data at 0xA4: bits 15:0 hold the base data and bits 31:16 hold the extended data.

A lock input freezes the mask and the data register. Two parameters can trim the block. One drops the extended data field. The other makes the whole register set inert when queued invalidation is unsupported.

Top module: `cmpl_irq_gen`

## Requirements
- R1: After reset, control reads 0x80000000 (mask set, pending clear), data reads 0, status reads 0 and msg_valid is low.
- R2: A completion pulse with the flag set, arriving while status bit 0 is clear, sets status bit 0 and control bit 30 after the clock edge. A pulse with the flag clear changes nothing.
- R3: A flagged completion that arrives while status bit 0 is already 1 creates no new pending flag and no message.
- R4: While the mask (control bit 31) is 1, a pending flag stays set and msg_valid stays low.
- R5: msg_valid is high whenever the pending flag is set and the mask is clear, including the cycle after software writes 0 to the mask. On the edge where msg_valid and msg_ready are both high, the pending flag clears, and msg_valid is low after that edge.
- R6: While msg_ready is low, msg_valid and the pending flag hold.
- R7: Writing 1 to status bit 0 clears it and clears the pending flag, and no message is issued.
- R8: msg_data equals the data register as read at 0xA4, and it is sampled at the handshake.
- R9: With EXT_DATA=0, data bits 31:16 read as zero, ignore writes and appear as zero on msg_data.
- R10: With QI_SUPPORTED=0, all registers read as zero, writes are ignored and msg_valid never rises.
- R11: While lock is high, writes to the mask bit and to the data register have no effect.
- R12: Control bits 29:0 always read as zero, and bit 30 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lock | input | 1 | Blocks writes to the mask bit and the data register |
| cmpl_pulse | input | 1 | Single-cycle wait-completion event |
| cmpl_irq | input | 1 | Interrupt-request flag carried by the completion |
| msg_valid | output | 1 | Interrupt message offered |
| msg_ready | input | 1 | Sink accepts the message |
| msg_data | output | 32 | Message data word |

## Verification
The hardest case to reach is a completion that arrives while the status bit is still set from an earlier event whose message has already been delivered. Only that case shows that the pending flag is edge-qualified rather than level-driven. The stimulus table reaches it by first unmasking, then completing the handshake, and then firing a second flagged completion without clearing the status bit. The test also covers the reverse path, where the status bit is cleared while a message is still held back by the mask. That test confirms that the pending flag drops and no message leaves.

// File: rtl/cmpl_irq_gen.sv
module cmpl_irq_gen #(
  parameter bit EXT_DATA     = 1'b1,
  parameter bit QI_SUPPORTED = 1'b1,
  parameter int AW           = 8,
  parameter logic [AW-1:0] STAT_OFS = 8'h9C,
  parameter logic [AW-1:0] CTRL_OFS = 8'hA0,
  parameter logic [AW-1:0] DATA_OFS = 8'hA4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          lock,
  input  logic          cmpl_pulse,
  input  logic          cmpl_irq,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [31:0]   msg_data
);
  localparam logic [31:0] EXT_MASK = EXT_DATA ? 32'hFFFF_FFFF : 32'h0000_FFFF;

  logic        wc, pend, mask;
  logic [31:0] data_q;

  wire wr_ok    = reg_wr && QI_SUPPORTED;
  wire clr_wc   = wr_ok && reg_addr == STAT_OFS && reg_wdata[0];
  wire wr_ctrl  = wr_ok && reg_addr == CTRL_OFS && !lock;
  wire wr_data  = wr_ok && reg_addr == DATA_OFS && !lock;
  wire new_cond = QI_SUPPORTED && cmpl_pulse && cmpl_irq && !wc;
  wire hs       = msg_valid && msg_ready;

  assign msg_valid = pend && !mask;
  assign msg_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc     <= 1'b0;
      pend   <= 1'b0;
      mask   <= 1'b1;
      data_q <= '0;
    end else begin
      wc <= wc ? !clr_wc : new_cond;
      if (new_cond)          pend <= 1'b1;
      else if (hs || clr_wc) pend <= 1'b0;
      if (wr_ctrl) mask   <= reg_wdata[31];
      if (wr_data) data_q <= reg_wdata & EXT_MASK;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (QI_SUPPORTED) begin
      unique case (reg_addr)
        STAT_OFS: reg_rdata = {31'd0, wc};
        CTRL_OFS: reg_rdata = {mask, pend, 30'd0};
        DATA_OFS: reg_rdata = data_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  // Pending never rises unless status was clear on the previous cycle (R3)
  p_edge_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(!wc));
  // A masked pending flag holds unless status is cleared (R4)
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && mask && !clr_wc) |=> pend);
  // Accepted message is not offered again (R5)
  p_one_msg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);
  // Stalled message holds its offer and data (R6)
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && !reg_wr) |=> (msg_valid && $stable(msg_data)));
  // Status clear drops pending (R7)
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wc && wc) |=> !pend);
  // Reserved control bits read zero (R12)
  p_rsvd_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_OFS) |-> (reg_rdata[29:0] == 30'd0));
endmodule

// File: tb/cmpl_irq_gen_tb.sv
module cmpl_irq_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'hA0;
  logic        reg_wr = 1'b0, lock = 1'b0, cmpl_pulse = 1'b0, cmpl_irq = 1'b0, msg_ready = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd0, rd1, rd2, md0, md1, md2;
  logic        mv0, mv1, mv2;
  int checks = 0, failures = 0, cyc = 0;

  always #4 clk = ~clk;

  cmpl_irq_gen u_dut (.clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata(rd0), .lock,
    .cmpl_pulse, .cmpl_irq, .msg_valid(mv0), .msg_ready, .msg_data(md0));
  cmpl_irq_gen #(.EXT_DATA(1'b0)) u_n16 (.clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata,
    .reg_rdata(rd1), .lock, .cmpl_pulse, .cmpl_irq, .msg_valid(mv1), .msg_ready, .msg_data(md1));
  cmpl_irq_gen #(.QI_SUPPORTED(1'b0)) u_nq (.clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata,
    .reg_rdata(rd2), .lock, .cmpl_pulse, .cmpl_irq, .msg_valid(mv2), .msg_ready, .msg_data(md2));

  task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
    end
  endtask

  // kind: 0 idle, 1 write, 2 completion
  task automatic cyc_do(input logic [1:0] kind, input logic [7:0] a, input logic [31:0] d,
                        input logic fl, input logic rdy);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = (kind == 2'd1);
    cmpl_pulse = (kind == 2'd2); cmpl_irq = fl; msg_ready = rdy;
    @(posedge clk);
    #1 reg_wr = 1'b0; cmpl_pulse = 1'b0; cmpl_irq = 1'b0; msg_ready = 1'b0; reg_addr = 8'hA0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a);
    reg_addr = a; #1;
  endtask

  // {kind, addr, wdata, flag, ready, exp_valid, exp_pend, req}
  localparam int NV = 13;
  localparam logic [49:0] VEC [NV] = '{
    {2'd2, 8'h00, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 unflagged ignored
    {2'd2, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 flagged sets pending
    {2'd0, 8'h00, 32'h0,         1'b0, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 masked hold
    {2'd1, 8'hA0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 unmask issues
    {2'd0, 8'h00, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 sink stall
    {2'd0, 8'h00, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 handshake clears
    {2'd2, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 status already set
    {2'd1, 8'h9C, 32'h1,         1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 clear status
    {2'd2, 8'h00, 32'h0,         1'b1, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 unmasked event
    {2'd1, 8'h9C, 32'h1,         1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 clear drops message
    {2'd1, 8'hA0, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 remask
    {2'd2, 8'h00, 32'h0,         1'b1, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 masked event
    {2'd1, 8'h9C, 32'h1,         1'b0, 1'b1, 1'b0, 1'b0, 4'd7}   // R7 clear while masked
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #20 rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(8'hA0); chk(1, rd0, 32'h8000_0000);
    rd(8'hA4); chk(1, rd0, 32'h0);
    rd(8'h9C); chk(1, rd0, 32'h0);
    chk(1, {31'd0, mv0}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      cyc_do(v[49:48], v[47:40], v[39:8], v[7], v[6]);
      chk(int'(v[3:0]), {31'd0, mv0}, {31'd0, v[5]});
      rd(8'hA0); chk(int'(v[3:0]), {31'd0, rd0[30]}, {31'd0, v[4]});
    end

    // R12 reserved bits and pending not writable
    cyc_do(2'd1, 8'hA0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rd(8'hA0); chk(12, rd0, 32'h8000_0000);
    // R11 lock blocks mask and data
    lock = 1'b1;
    cyc_do(2'd1, 8'hA0, 32'h0, 1'b0, 1'b0);
    rd(8'hA0); chk(11, rd0, 32'h8000_0000);
    cyc_do(2'd1, 8'hA4, 32'h1234_5678, 1'b0, 1'b0);
    rd(8'hA4); chk(11, rd0, 32'h0);
    lock = 1'b0;
    // R8 data on message
    cyc_do(2'd1, 8'hA4, 32'hDEAD_BEEF, 1'b0, 1'b0);
    rd(8'hA4); chk(8, rd0, 32'hDEAD_BEEF);
    // R9 extended field absent
    chk(9, rd1, 32'h0000_BEEF);
    chk(9, md1, 32'h0000_BEEF);
    // R10 inert without queued invalidation
    chk(10, rd2, 32'h0);
    cyc_do(2'd1, 8'hA0, 32'h0, 1'b0, 1'b0);
    cyc_do(2'd2, 8'h00, 32'h0, 1'b1, 1'b0);
    chk(8, {31'd0, mv0}, 32'd1);
    chk(8, md0, 32'hDEAD_BEEF);
    chk(10, {31'd0, mv2}, 32'd0);
    rd(8'hA0); chk(10, rd2, 32'h0);
    rd(8'h9C); chk(10, rd2, 32'h0);
    cyc_do(2'd0, 8'h00, 32'h0, 1'b0, 1'b1);
    chk(5, {31'd0, mv0}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule